// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupt

This block is a general-purpose I/O port with eight pins. Each pin has a two-bit mode field that makes it an open-drain output, a push-pull output or an input. A single output-level register sets what the output pins drive. Reading that register returns the synchronized levels seen on the pads, not the stored value. The pad side of the block is a set of plain output-level, output-enable and input vectors, which the chip's pad ring turns into real pads.

A separate edge input can raise an interrupt. Its control register holds an enable bit, a polarity bit and a sticky flag. When the port is enabled and the chosen edge arrives, the flag sets and the active-low interrupt output falls. A register read of the control register clears the flag. The edge input and the pad inputs each pass through a synchronizer before they are used.

A host reaches all registers through a simple single-cycle read/write port. Read data is combinational from the address, and writes and read side effects take place on the rising clock edge.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every mode field, the output-level register, the edge enable, the edge polarity and the edge flag are 0, and irq_n is 1. All pins are therefore open-drain with level 0, so pad_oe is all ones and pad_out is all zeros.
- R2: The mode of pin p sits in the register at address p/4, bits [2*(p%4)+1 : 2*(p%4)]. Addresses 0x0 and 0x1 read back the last value written to them.
- R3: In mode 00 (open-drain) pad_out[p] is 0 and pad_oe[p] is the inverse of output-level bit p.
- R4: In mode 10 (push-pull) pad_oe[p] is 1 and pad_out[p] equals output-level bit p.
- R5: In modes 01 and 11 (input) pad_oe[p] and pad_out[p] are 0.
- R6: A write to address 0x2 sets the output-level register. A read of address 0x2 returns pad_in as it was sampled two rising edges earlier.
- R7: Address 0x3 is the edge control register. Bit 7 is the flag, bit 6 the enable and bit 5 the polarity, and bits 4..0 read as 0. A write updates only the enable and the polarity; bit 7 of the written data has no effect on the flag.
- R8: With the enable at 1 and the polarity at 0, a 0-to-1 change on edge_in sets the flag on the third rising edge after the change, and irq_n is the inverse of the flag.
- R9: With the polarity at 1, only a 1-to-0 change on edge_in sets the flag; a 0-to-1 change leaves it clear.
- R10: With the enable at 0, no change on edge_in sets the flag.
- R11: A read of address 0x3 clears the flag on that clock edge. If a qualifying edge is detected in the same cycle, the flag stays set.
- R12: Addresses 0x4 and above read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the read side effects) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| pad_in | input | NUM_PINS | Levels seen on the pads |
| pad_out | output | NUM_PINS | Level to drive on each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |
| edge_in | input | 1 | Edge interrupt source |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: eight pins, eight-bit registers, a four-bit address and two synchronizer stages. With these values both mode registers, and so every one of the four field positions in each register, are reachable at the fixed addresses 0x0 to 0x3. The two-stage latency lets the bench place a clearing read in exactly the cycle in which an edge is detected. The address space also leaves twelve unmapped addresses for the ignored-write and read-zero cases.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   typedef enum logic [1:0] {
      PIN_OPEN_DRAIN = 2'b00,
      PIN_INPUT      = 2'b01,
      PIN_PUSH_PULL  = 2'b10,
      PIN_INPUT_ALT  = 2'b11
   } pin_mode_e;

   localparam int MODE_W = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv import gpio_edge_pkg::*; (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              level_i,
   output logic              out_o,
   output logic              oe_o
);
   always_comb begin
      unique case (pin_mode_e'(mode_i))
         PIN_OPEN_DRAIN: begin
            out_o = 1'b0;
            oe_o  = ~level_i;
         end
         PIN_PUSH_PULL: begin
            out_o = level_i;
            oe_o  = 1'b1;
         end
         default: begin
            out_o = 1'b0;
            oe_o  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic en_i,
   input  logic pol_i,
   input  logic clr_i,
   output logic hit_o,
   output logic flag_o
);
   logic cur_s;
   logic prev_q;
   logic flag_q;

   gpio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (edge_i),
      .q_o   (cur_s)
   );

   assign hit_o = en_i & (pol_i ? (prev_q & ~cur_s) : (~prev_q & cur_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= cur_s;
         flag_q <= hit_o | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;

   // R8 / R10: the flag can only rise while the enable was set
   a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(en_i));
   // R11: a clearing read without a coincident edge empties the flag
   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit_o) |=> !flag_q);
   // R11: a detected edge always leaves the flag set, even against a clear
   a_r11_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> flag_q);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port import gpio_edge_pkg::*; #(
   parameter int NUM_PINS    = 8,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic                edge_in,
   output logic                irq_n
);
   localparam int FIELDS_PER_REG = DATA_W / MODE_W;
   localparam int NUM_CFG        = NUM_PINS / FIELDS_PER_REG;
   localparam int ADDR_LEVEL     = NUM_CFG;
   localparam int ADDR_EDGE      = NUM_CFG + 1;
   localparam int FLAG_BIT       = DATA_W - 1;
   localparam int EN_BIT         = DATA_W - 2;
   localparam int POL_BIT        = DATA_W - 3;

   generate
      if (DATA_W < 4 || (DATA_W % MODE_W) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 4");
      end
      if (NUM_PINS > DATA_W || (NUM_PINS % FIELDS_PER_REG) != 0) begin : g_bad_pins
         $error("NUM_PINS must be a multiple of DATA_W/2 and fit in DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << ADDR_W) <= ADDR_EDGE) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [DATA_W-1:0]   cfg_q [NUM_CFG];
   logic [NUM_PINS-1:0] level_q;
   logic                en_q;
   logic                pol_q;
   logic                flag;
   logic                hit;
   logic [NUM_PINS-1:0] pins_s;
   logic                sel_level;
   logic                sel_edge;

   assign sel_level = (reg_addr == ADDR_W'(ADDR_LEVEL));
   assign sel_edge  = (reg_addr == ADDR_W'(ADDR_EDGE));

   // mode registers, one per group of FIELDS_PER_REG pins
   generate
      for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[r] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(r)) cfg_q[r] <= reg_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         en_q    <= 1'b0;
         pol_q   <= 1'b0;
      end else if (reg_wr) begin
         if (sel_level) level_q <= reg_wdata[NUM_PINS-1:0];
         if (sel_edge) begin
            en_q  <= reg_wdata[EN_BIT];
            pol_q <= reg_wdata[POL_BIT];
         end
      end
   end

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_in),
      .q_o   (pins_s)
   );

   gpio_edge_irq #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (edge_in),
      .en_i   (en_q),
      .pol_i  (pol_q),
      .clr_i  (reg_rd & sel_edge),
      .hit_o  (hit),
      .flag_o (flag)
   );

   assign irq_n = ~flag;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         localparam int RI = p / FIELDS_PER_REG;
         localparam int FI = p % FIELDS_PER_REG;
         logic [MODE_W-1:0] mode;
         assign mode = cfg_q[RI][FI*MODE_W +: MODE_W];

         gpio_pin_drv u_drv (
            .mode_i  (mode),
            .level_i (level_q[p]),
            .out_o   (pad_out[p]),
            .oe_o    (pad_oe[p])
         );

         // R3: open-drain never drives a high level
         a_r3_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == PIN_OPEN_DRAIN) |-> (!pad_out[p] && (pad_oe[p] != level_q[p])));
         // R4: push-pull always drives the stored level
         a_r4_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == PIN_PUSH_PULL) |-> (pad_oe[p] && pad_out[p] == level_q[p]));
         // R5: both input encodings release the pad
         a_r5_input_released: assert property (@(posedge clk) disable iff (!rst_n)
            mode[0] |-> (!pad_oe[p] && !pad_out[p]));
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int r = 0; r < NUM_CFG; r++) begin
         if (reg_addr == ADDR_W'(r)) reg_rdata = cfg_q[r];
      end
      if (sel_level) reg_rdata = DATA_W'(pins_s);
      if (sel_edge) begin
         reg_rdata[FLAG_BIT] = flag;
         reg_rdata[EN_BIT]   = en_q;
         reg_rdata[POL_BIT]  = pol_q;
      end
   end

   // R7: spare bits of the edge register read as zero
   a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sel_edge |-> (reg_rdata[POL_BIT-1:0] == '0));
   // R12: addresses past the map read as zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_addr) > ADDR_EDGE) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out;
   logic [7:0] pad_oe;
   logic       edge_in = 1'b0;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_edge_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .edge_in(edge_in), .irq_n(irq_n)
   );

   // behavioural reference model
   logic [7:0] m_cfg0, m_cfg1, m_lvl, m_pin1, m_pin2;
   bit m_en, m_pol, m_flag, m_e1, m_e2, m_eprev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg0 = 0; m_cfg1 = 0; m_lvl = 0; m_pin1 = 0; m_pin2 = 0;
         m_en = 0; m_pol = 0; m_flag = 0; m_e1 = 0; m_e2 = 0; m_eprev = 0;
      end else begin
         bit hit;
         hit = m_en && (m_pol ? (m_eprev && !m_e2) : (!m_eprev && m_e2));
         m_flag = hit || (m_flag && !(reg_rd && reg_addr == 4'h3));
         if (reg_wr) begin
            case (reg_addr)
               4'h0: m_cfg0 = reg_wdata;
               4'h1: m_cfg1 = reg_wdata;
               4'h2: m_lvl = reg_wdata;
               4'h3: begin m_en = reg_wdata[6]; m_pol = reg_wdata[5]; end
               default: ;
            endcase
         end
         m_eprev = m_e2; m_e2 = m_e1; m_e1 = edge_in;
         m_pin2 = m_pin1; m_pin1 = pad_in;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(logic [3:0] a);
      case (a)
         4'h0: return m_cfg0;
         4'h1: return m_cfg1;
         4'h2: return m_pin2;
         4'h3: return {m_flag, m_en, m_pol, 5'b0};
         default: return 8'h00;
      endcase
   endfunction

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string rtag;
         rtag = (reg_addr < 2) ? "R2" : (reg_addr == 2) ? "R6" : (reg_addr == 3) ? "R7" : "R12";
         chk(rtag, reg_rdata, m_read(reg_addr));
         chk("R8 irq", irq_n, !m_flag);
         for (int p = 0; p < 8; p++) begin
            logic [1:0] md;
            bit eo, ee;
            md = (p < 4) ? m_cfg0[2*p +: 2] : m_cfg1[2*(p-4) +: 2];
            if (md == 2'b00) begin eo = 0; ee = !m_lvl[p]; end
            else if (md == 2'b10) begin eo = m_lvl[p]; ee = 1; end
            else begin eo = 0; ee = 0; end
            chk(md == 2'b00 ? "R3" : md == 2'b10 ? "R4" : "R5",
                {pad_oe[p], pad_out[p]}, {ee, eo});
         end
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
   endtask

   task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
      reg_addr = a; reg_rd = 1; #2; chk(tag, reg_rdata, exp); step(); reg_rd = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3); rst_n = 1; step();
      // R1 reset state
      rd(4'h0, 8'h00, "R1 cfg0"); rd(4'h1, 8'h00, "R1 cfg1");
      rd(4'h3, 8'h00, "R1 edge"); chk("R1 irq", irq_n, 1);
      chk("R1 oe", pad_oe, 8'hFF); chk("R1 out", pad_out, 8'h00);
      // modes: pin3..0 = 11 10 01 00, pin7..4 = 00 01 10 11
      wr(4'h0, 8'hE4); wr(4'h1, 8'h1B);
      rd(4'h0, 8'hE4, "R2 cfg0"); rd(4'h1, 8'h1B, "R2 cfg1");
      wr(4'h2, 8'hA5);
      chk("R4 oe A5", pad_oe, 8'h24); chk("R4 out A5", pad_out, 8'h24);
      wr(4'h2, 8'h5A);
      chk("R3 oe 5A", pad_oe, 8'hA5); chk("R3 out 5A", pad_out, 8'h00);
      wr(4'h0, 8'h55); wr(4'h1, 8'hFF);
      chk("R5 oe", pad_oe, 8'h00); chk("R5 out", pad_out, 8'h00);
      // R6 pad levels
      pad_in = 8'h3C; reg_addr = 4'h2; step(2);
      rd(4'h2, 8'h3C, "R6 pins 3C");
      pad_in = 8'hC1; step(2); rd(4'h2, 8'hC1, "R6 pins C1");
      // R12 unmapped
      wr(4'h7, 8'hFF); rd(4'h7, 8'h00, "R12 read");
      rd(4'h0, 8'h55, "R12 cfg0 kept"); rd(4'h3, 8'h00, "R12 edge kept");
      // R7 write of bit 7 does not set the flag; R8 rising edge
      wr(4'h3, 8'hC0); step(3); chk("R7 no set", irq_n, 1);
      edge_in = 1; step(2); chk("R8 not yet", irq_n, 1);
      step(); chk("R8 set", irq_n, 0);
      rd(4'h3, 8'hC0, "R7 layout"); chk("R11 cleared", irq_n, 1);
      // R9 falling polarity
      wr(4'h3, 8'h60); edge_in = 0; step(4); chk("R9 fall sets", irq_n, 0);
      rd(4'h3, 8'hE0, "R9 read"); edge_in = 1; step(4);
      chk("R9 rise ignored", irq_n, 1);
      // R10 disabled
      wr(4'h3, 8'h00); edge_in = 0; step(4); edge_in = 1; step(4);
      chk("R10 no flag", irq_n, 1); rd(4'h3, 8'h00, "R10 read");
      // R11 edge coinciding with clearing read
      wr(4'h3, 8'h40); edge_in = 0; step(4); edge_in = 1; step(4);
      chk("R11 pre", irq_n, 0);
      edge_in = 0; step(4); edge_in = 1; step(2);
      rd(4'h3, 8'hC0, "R11 read at hit"); chk("R11 edge wins", irq_n, 0);
      rd(4'h3, 8'hC0, "R11 second read"); chk("R11 then clear", irq_n, 1);
      step(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule